// File: doc/BRIEF.md
# Calibration Coefficient Loader with Integrity Check

This block fetches a stored calibration record from a non-volatile memory, one word at a time, through a simple request/response read port. It runs once, by itself, when reset is released, and again each time a start pulse arrives after a finished load. It accumulates a CRC-32 over the record as the words arrive and keeps the coefficient words in a private staging bank. After the last word it checks integrity first, then the record's format version, then the device identity word.

Only a record that passes every check reaches the runtime coefficient outputs. The whole set is copied in a single clock, so downstream compensation logic never sees a mix of old and new words. A record that fails, or a memory that stops answering, causes a built-in default set to be loaded instead. The block then reports a reason code, a CRC status bit and the ID of the set now in force, so the host always knows which coefficients are active and why.

The read request follows valid/ready rules. The loader raises `rd_req_o` with `rd_addr_o` and holds both unchanged until it samples `rd_ready_i` high at a clock edge, which is the back-pressure point. It then lowers the request and waits for a one-cycle `rd_rvalid_i` carrying `rd_rdata_i`. At most one read is outstanding, and the response path has no back-pressure: the loader always takes the word.

Top module: `cal_coef_loader`

## Requirements
- R1: While reset is held, `rd_req_o`, `busy_o`, `done_o`, `fallback_o` and `crc_ok_o` are 0, `reason_o` is 0, `active_id_o` is the default ID 0x0000, and every coefficient word is the default 0x00010000.
- R2: After reset is released, a load starts without any start pulse. It reads addresses 0 to N_COEF+2 once each, in ascending order, with one read outstanding at a time. Address 0 is the header, with the format version in bits 31:16 and the calibration ID in bits 15:0. Address 1 is the device identity word. Addresses 2 to N_COEF+1 are the coefficients, with coefficient i at address i+2. Address N_COEF+2 holds the stored CRC.
- R3: The CRC is CRC-32 with polynomial 0x04C11DB7 and an all-ones start value. Each word from address 0 to N_COEF+1 is shifted in MSB first, and the result is inverted. A record whose CRC matches, whose version equals FMT_VER (default 3), and whose identity word equals `dev_uid_i` is committed. The outputs then show the record's coefficients, `active_id_o` equal to the header ID, `fallback_o` = 0, `crc_ok_o` = 1 and `reason_o` = 0.
- R4: On a CRC mismatch the default set and default ID are loaded, with `fallback_o` = 1, `crc_ok_o` = 0 and `reason_o` = 1. A CRC mismatch takes priority over a bad version or a bad identity word.
- R5: A record with a valid CRC and the wrong format version is refused. The defaults are loaded, with `reason_o` = 2, `fallback_o` = 1 and `crc_ok_o` = 1.
- R6: A record with a valid CRC, the right version and the wrong identity word is refused. The defaults are loaded, with `reason_o` = 3, `fallback_o` = 1 and `crc_ok_o` = 1.
- R7: If no read response arrives for TIMEOUT (default 1024) consecutive cycles during a load, the defaults are loaded, with `reason_o` = 4, `fallback_o` = 1 and `crc_ok_o` = 0. A later load can still commit normally.
- R8: While a load is in progress, the coefficient outputs, `active_id_o`, `fallback_o`, `crc_ok_o` and `reason_o` keep the previous result, and `done_o` is 0. All of them change together in the cycle in which `done_o` rises.
- R9: A start pulse after `done_o` begins a new load. A start pulse while `busy_o` is 1 is ignored: the load in progress continues, makes exactly N_COEF+3 reads in order, and gives its normal result.
- R10: While `rd_req_o` is 1 and `rd_ready_i` is 0, `rd_req_o` stays 1 and `rd_addr_o` stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Pulse to request a reload |
| dev_uid_i | input | 32 | Identity word of this device |
| rd_req_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Memory accepts the request |
| rd_addr_o | output | AW | Word address of the request |
| rd_rvalid_i | input | 1 | Read data valid (one cycle) |
| rd_rdata_i | input | 32 | Read data word |
| coef_o | output | 32*N_COEF | Runtime coefficient set, word i at bits 32*i+31:32*i |
| active_id_o | output | 16 | ID of the active set |
| crc_ok_o | output | 1 | Stored CRC matched on the last load |
| fallback_o | output | 1 | Defaults are active |
| reason_o | output | 3 | Fallback reason code |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Last load finished |

## Verification
A wrong word index inside the loader shows at the read port as an address out of sequence, or as a read count other than N_COEF+3. A failure of the staging bank or the CRC register appears only after `done_o` rises, as a wrong reason code or a wrong coefficient word. Each stimulus vector therefore plants one defect in the stored record and compares the whole output set once `done_o` is high. The mid-load samples catch an early commit before `done_o` rises. The timeout case measures how many cycles pass until `done_o` rises.

// File: rtl/cal_ld_pkg.sv
package cal_ld_pkg;
  localparam int          WORD_W   = 32;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_PAY, ST_CHECK, ST_COMMIT, ST_FALLBK, ST_DONE
  } ld_state_t;

  typedef enum logic [2:0] {
    RSN_OK  = 3'd0,
    RSN_CRC = 3'd1,
    RSN_VER = 3'd2,
    RSN_UID = 3'd3,
    RSN_TMO = 3'd4
  } ld_reason_t;

  // Shift one word into the CRC register, most significant bit first.
  function automatic logic [31:0] crc32_word(input logic [31:0] c_in,
                                             input logic [31:0] d);
    logic [31:0] c;
    c = c_in;
    for (int b = 31; b >= 0; b--) begin
      if (c[31] ^ d[b]) c = {c[30:0], 1'b0} ^ CRC_POLY;
      else              c = {c[30:0], 1'b0};
    end
    return c;
  endfunction
endpackage

// File: rtl/cal_ld_crc.sv
module cal_ld_crc
  import cal_ld_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              upd_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [31:0]       crc_o
);
  always_ff @(posedge clk) begin
    if (!rst_n || init_i) crc_o <= '1;
    else if (upd_i)       crc_o <= crc32_word(crc_o, word_i);
  end

  // R3: every load begins from the all-ones register value
  a_r3_crc_seed: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> crc_o == 32'hFFFF_FFFF);
endmodule

// File: rtl/cal_ld_tmo.sv
module cal_ld_tmo #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !arm_i || kick_i) cnt_q <= '0;
    else if (cnt_q != CNT_MAX)      cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = arm_i && !kick_i && (cnt_q == CNT_MAX);

  // R7: the loader leaves its read states right after expiry
  a_r7_expire_exit: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !arm_i);
endmodule

// File: rtl/cal_ld_bank.sv
module cal_ld_bank
  import cal_ld_pkg::*;
#(
  parameter int                N_COEF   = 8,
  parameter int                AW       = 4,
  parameter int                BASE     = 2,
  parameter logic [WORD_W-1:0] DEF_COEF = 32'h0001_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            wr_idx_i,
  input  logic [WORD_W-1:0]        wr_data_i,
  input  logic                     commit_i,
  input  logic                     dflt_i,
  output logic [N_COEF*WORD_W-1:0] coef_o
);
  for (genvar i = 0; i < N_COEF; i++) begin : g_word
    logic [WORD_W-1:0] stage_q;
    logic [WORD_W-1:0] run_q;

    always_ff @(posedge clk) begin
      if (!rst_n)                                         stage_q <= '0;
      else if (wr_en_i && wr_idx_i == AW'(i + BASE))      stage_q <= wr_data_i;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)        run_q <= DEF_COEF;
      else if (commit_i) run_q <= stage_q;
      else if (dflt_i)   run_q <= DEF_COEF;
    end

    assign coef_o[i*WORD_W +: WORD_W] = run_q;
  end

  // R8: the runtime set moves only on a commit or a fallback
  a_r8_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i && !dflt_i |=> $stable(coef_o));
endmodule

// File: rtl/cal_coef_loader.sv
module cal_coef_loader
  import cal_ld_pkg::*;
#(
  parameter int          N_COEF   = 8,
  parameter int          TIMEOUT  = 1024,
  parameter logic [15:0] FMT_VER  = 16'h0003,
  parameter logic [15:0] DEF_ID   = 16'h0000,
  parameter logic [31:0] DEF_COEF = 32'h0001_0000,
  localparam int         AW       = $clog2(N_COEF + 3)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [31:0]              dev_uid_i,
  output logic                     rd_req_o,
  input  logic                     rd_ready_i,
  output logic [AW-1:0]            rd_addr_o,
  input  logic                     rd_rvalid_i,
  input  logic [31:0]              rd_rdata_i,
  output logic [N_COEF*WORD_W-1:0] coef_o,
  output logic [15:0]              active_id_o,
  output logic                     crc_ok_o,
  output logic                     fallback_o,
  output logic [2:0]               reason_o,
  output logic                     busy_o,
  output logic                     done_o
);
  localparam logic [AW-1:0] LAST = AW'(N_COEF + 2);

  ld_state_t   state_q;
  ld_reason_t  rsn_q, rsn_out_q;
  logic [AW-1:0] idx_q;
  logic        waiting_q, por_q, crc_chk_q, crc_ok_q, fb_q;
  logic [31:0] hdr_q, uid_q, crcw_q, crc_val;
  logic [15:0] act_id_q;
  logic        reading, beat, go, tmo_exp, crc_match;

  assign reading   = (state_q == ST_HDR) || (state_q == ST_PAY);
  assign beat      = reading && waiting_q && rd_rvalid_i;
  assign go        = ((state_q == ST_IDLE) && (por_q || start_i)) ||
                     ((state_q == ST_DONE) && start_i);
  assign crc_match = (~crc_val == crcw_q);

  cal_ld_crc u_crc (
    .clk(clk), .rst_n(rst_n), .init_i(go),
    .upd_i(beat && idx_q != LAST), .word_i(rd_rdata_i), .crc_o(crc_val)
  );

  cal_ld_tmo #(.LIMIT(TIMEOUT)) u_tmo (
    .clk(clk), .rst_n(rst_n), .arm_i(reading),
    .kick_i(rd_rvalid_i), .expire_o(tmo_exp)
  );

  cal_ld_bank #(.N_COEF(N_COEF), .AW(AW), .BASE(2), .DEF_COEF(DEF_COEF)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en_i(beat), .wr_idx_i(idx_q),
    .wr_data_i(rd_rdata_i), .commit_i(state_q == ST_COMMIT),
    .dflt_i(state_q == ST_FALLBK), .coef_o(coef_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      waiting_q <= 1'b0;
      por_q     <= 1'b1;
      hdr_q     <= '0;
      uid_q     <= '0;
      crcw_q    <= '0;
      rsn_q     <= RSN_OK;
      rsn_out_q <= RSN_OK;
      crc_chk_q <= 1'b0;
      crc_ok_q  <= 1'b0;
      fb_q      <= 1'b0;
      act_id_q  <= DEF_ID;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: if (go) begin
          state_q   <= ST_HDR;
          idx_q     <= '0;
          waiting_q <= 1'b0;
          por_q     <= 1'b0;
        end
        ST_HDR, ST_PAY: begin
          if (tmo_exp) begin
            rsn_q     <= RSN_TMO;
            crc_chk_q <= 1'b0;
            state_q   <= ST_FALLBK;
          end else begin
            if (rd_req_o && rd_ready_i) waiting_q <= 1'b1;
            if (beat) begin
              waiting_q <= 1'b0;
              idx_q     <= idx_q + 1'b1;
              if (idx_q == '0) hdr_q <= rd_rdata_i;
              if (idx_q == AW'(1)) begin
                uid_q   <= rd_rdata_i;
                state_q <= ST_PAY;
              end
              if (idx_q == LAST) begin
                crcw_q  <= rd_rdata_i;
                state_q <= ST_CHECK;
              end
            end
          end
        end
        ST_CHECK: begin
          crc_chk_q <= crc_match;
          if (!crc_match)                 rsn_q <= RSN_CRC;
          else if (hdr_q[31:16] != FMT_VER) rsn_q <= RSN_VER;
          else if (uid_q != dev_uid_i)    rsn_q <= RSN_UID;
          else                            rsn_q <= RSN_OK;
          state_q <= (crc_match && hdr_q[31:16] == FMT_VER && uid_q == dev_uid_i)
                     ? ST_COMMIT : ST_FALLBK;
        end
        ST_COMMIT: begin
          fb_q      <= 1'b0;
          rsn_out_q <= RSN_OK;
          crc_ok_q  <= crc_chk_q;
          act_id_q  <= hdr_q[15:0];
          state_q   <= ST_DONE;
        end
        ST_FALLBK: begin
          fb_q      <= 1'b1;
          rsn_out_q <= rsn_q;
          crc_ok_q  <= crc_chk_q;
          act_id_q  <= DEF_ID;
          state_q   <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o    = reading && !waiting_q;
  assign rd_addr_o   = idx_q;
  assign busy_o      = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o      = (state_q == ST_DONE);
  assign active_id_o = act_id_q;
  assign crc_ok_o    = crc_ok_q;
  assign fallback_o  = fb_q;
  assign reason_o    = rsn_out_q;

  // R10: a stalled request keeps its valid and address
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_ready_i |=> rd_req_o && $stable(rd_addr_o));
  // R2: requests never run past the CRC word
  a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> rd_addr_o <= LAST);
  // R3: a committed result always carries a clean status
  a_r3_commit_status: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !fallback_o |-> crc_ok_o && reason_o == 3'd0);
  // R4: a fallback always names a reason
  a_r4_fallback_reason: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && fallback_o |-> reason_o != 3'd0);
  // R8: reported status holds while a load runs
  a_r8_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(active_id_o) && $stable(fallback_o)
                                && $stable(reason_o) && $stable(crc_ok_o));
endmodule

// File: tb/cal_coef_loader_bench.sv
module cal_coef_loader_bench;
  localparam int          CLK_P = 10;
  localparam int          N     = 8;
  localparam int          LASTW = N + 2;
  localparam logic [31:0] DEFW  = 32'h0001_0000;
  localparam logic [15:0] VER   = 16'h0003;
  localparam logic [31:0] UID   = 32'hA5C3_1E77;
  localparam logic [31:0] POLY  = 32'h04C11DB7;
  // [11:8] defect kind, [7:4] response latency, [3] ready stall, [2:0] expected reason
  localparam logic [11:0] VEC [8] = '{12'h000, 12'h038, 12'h111, 12'h20A,
                                      12'h323, 12'h401, 12'h519, 12'h050};

  logic            clk = 1'b0;
  logic            rst_n, start, rd_req, rd_ready, rd_rvalid;
  logic [3:0]      rd_addr;
  logic [31:0]     rd_rdata, dev_uid;
  logic [N*32-1:0] coef;
  logic [15:0]     act_id;
  logic            crc_ok, fallback, busy, done;
  logic [2:0]      reason;

  logic [31:0] mem [0:LASTW];
  logic        mute, stall, pend;
  int          lat, lat_cnt, pend_addr, reads, exp_addr, order_err;
  int          checks = 0, errors = 0;
  logic        cur_ok;
  logic [15:0] cur_id;

  always #(CLK_P/2) clk = ~clk;

  cal_coef_loader u_cal_coef_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .dev_uid_i(dev_uid),
    .rd_req_o(rd_req), .rd_ready_i(rd_ready), .rd_addr_o(rd_addr),
    .rd_rvalid_i(rd_rvalid), .rd_rdata_i(rd_rdata), .coef_o(coef),
    .active_id_o(act_id), .crc_ok_o(crc_ok), .fallback_o(fallback),
    .reason_o(reason), .busy_o(busy), .done_o(done)
  );

  // Memory responder, driven away from the active edge
  initial begin
    rd_ready = 1'b0; rd_rvalid = 1'b0; rd_rdata = '0; pend = 1'b0;
    forever begin
      @(negedge clk);
      rd_rvalid = 1'b0;
      if (!rst_n) begin
        pend = 1'b0; rd_ready = 1'b0;
      end else begin
        if (pend && !mute) begin
          if (lat_cnt == 0) begin
            rd_rvalid = 1'b1; rd_rdata = mem[pend_addr]; pend = 1'b0;
          end else lat_cnt--;
        end
        rd_ready = stall ? ~rd_ready : 1'b1;
        if (!pend && rd_req && rd_ready) begin
          pend = 1'b1; lat_cnt = lat; pend_addr = int'(rd_addr);
          if (int'(rd_addr) != exp_addr) order_err++;
          exp_addr++; reads++;
        end
      end
    end
  end

  function automatic logic [31:0] tb_crc(input int nw);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int w = 0; w < nw; w++)
      for (int k = 3; k >= 0; k--)
        for (int j = 7; j >= 0; j--) begin
          logic top = r[31] ^ mem[w][8*k + j];
          r = r << 1;
          if (top) r = r ^ POLY;
        end
    return ~r;
  endfunction

  function automatic logic [31:0] rec_word(input logic [15:0] id, input int i);
    return {id, 16'(i * 291 + 17)};
  endfunction

  task automatic build(input int kind, input logic [15:0] id);
    mem[0] = {VER, id};
    mem[1] = UID;
    for (int i = 0; i < N; i++) mem[2 + i] = rec_word(id, i);
    if (kind == 2) mem[0][31:16] = VER + 16'd1;
    if (kind == 3) mem[1] = ~UID;
    mem[LASTW] = tb_crc(LASTW);
    if (kind == 1) mem[4][9] = ~mem[4][9];
    if (kind == 4) mem[0][31:16] = VER + 16'd2;
    if (kind == 5) mem[LASTW] = mem[LASTW] ^ 32'h0000_8000;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_set(input string req, input logic ok, input logic [15:0] id);
    for (int i = 0; i < N; i++)
      chk(req, coef[i*32 +: 32], ok ? rec_word(id, i) : DEFW);
    chk(req, {16'd0, act_id}, ok ? {16'd0, id} : 32'd0);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 4000) begin @(negedge clk); n++; end
    if (!done) chk("watchdog", 32'd0, 32'd1);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; start = 1'b0; dev_uid = UID;
    mute = 1'b0; stall = 1'b0; lat = 0; reads = 0; exp_addr = 0; order_err = 0;
    cur_ok = 1'b0; cur_id = 16'h0000;
    build(0, 16'h1000);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rd_req", {31'd0, rd_req}, 32'd0);
    chk("R1 busy/done", {30'd0, busy, done}, 32'd0);
    chk("R1 status", {28'd0, fallback, crc_ok, reason}, 32'd0);
    chk_set("R1 defaults", 1'b0, 16'h0000);
    rst_n = 1'b1;

    for (int v = 0; v < 8; v++) begin
      logic [15:0] id = 16'h1000 + 16'(v);
      int kind = int'(VEC[v][11:8]);
      logic [2:0] ers = VEC[v][2:0];
      if (v > 0) begin
        lat = int'(VEC[v][7:4]); stall = VEC[v][3];
        build(kind, id);
        reads = 0; exp_addr = 0; order_err = 0;
        pulse_start();
        repeat (4) @(negedge clk);
        // R8: nothing moves before the load finishes
        chk("R8 done low mid-load", {31'd0, done}, 32'd0);
        chk_set("R8 set held mid-load", cur_ok, cur_id);
        // R9: second start while busy is ignored
        pulse_start();
      end
      wait_done(n);
      chk("R2/R9 read count", reads, LASTW + 1);
      chk("R2 address order", order_err, 0);
      chk(ers == 0 ? "R3 reason" : ers == 1 ? "R4 reason" :
          ers == 2 ? "R5 reason" : "R6 reason", {29'd0, reason}, {29'd0, ers});
      chk("R3/R4 fallback", {31'd0, fallback}, {31'd0, ers != 0});
      chk("R3/R4 crc_ok", {31'd0, crc_ok}, {31'd0, ers != 1});
      cur_ok = (ers == 0); cur_id = cur_ok ? id : 16'h0000;
      chk_set(ers == 0 ? "R3 commit set" : "R4/R5/R6 default set", cur_ok, cur_id);
    end

    // R7: silent memory leads to timeout fallback
    lat = 0; stall = 1'b0; mute = 1'b1;
    pulse_start();
    wait_done(n);
    chk("R7 timeout window", {31'd0, (n >= 1020 && n <= 1040)}, 32'd1);
    chk("R7 reason", {29'd0, reason}, 32'd4);
    chk("R7 fallback/crc_ok", {30'd0, fallback, crc_ok}, 32'd2);
    chk_set("R7 default set", 1'b0, 16'h0000);

    // R7/R9: recovery load after timeout
    mute = 1'b0; pend = 1'b0;
    build(0, 16'h7777);
    reads = 0; exp_addr = 0; order_err = 0;
    pulse_start();
    wait_done(n);
    chk("R7 recovery reason", {29'd0, reason}, 32'd0);
    chk("R9 recovery reads", reads, LASTW + 1);
    chk_set("R7 recovery set", 1'b1, 16'h7777);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule